// File: doc/BRIEF.md
# Register-File Bus Slave with Selectable Acknowledge Timing

This block is a classic single-slave bus target placed in front of a small word-organised register file. A master opens a cycle with `cyc` and `stb`, and it presents an address, a write flag, byte-lane enables and write data. The slave acknowledges each beat with `ack`. On a write beat it updates the enabled byte lanes. On a read beat it returns the addressed word on `dat_r`, which is valid while `ack` is high.

The parameter `REG_ACK` sets when the acknowledge arrives. With `REG_ACK = 0`, `ack` and read data are produced in the same cycle as the request, so a held strobe gets one beat per clock. With `REG_ACK = 1`, a two-state machine with the states IDLE and RESPOND drives `ack` and the read data from flip-flops. The transition IDLE→RESPOND is taken on a request (`cyc && stb`). The transition RESPOND→IDLE is taken unconditionally. The response therefore lands one clock after the request, and a held strobe is acknowledged at most every second clock. This cuts the master-to-slave timing path at the cost of latency and, in the worst case, half the bandwidth.

Top module: `wbs_regfile_slave`

## Requirements
- R1: While reset is high and after it is released, `ack` is low and every register-file word reads as zero.
- R2: With REG_ACK=0, `ack` is high in the same cycle that `cyc` and `stb` are both high, and `dat_r` then holds the addressed word.
- R3: With REG_ACK=0, a burst that keeps `cyc` and `stb` high is acknowledged on every clock, so N beats take N cycles.
- R4: With REG_ACK=1, `ack` rises exactly one cycle after a request is presented from the idle state, and `dat_r` then holds the word addressed at request time.
- R5: With REG_ACK=1, `ack` is never high in two consecutive cycles, so a held strobe completes N beats in 2N cycles.
- R6: `ack` is low in every cycle in which `cyc` or `stb` is low. `stb` without `cyc` causes no acknowledge and no write.
- R7: A write beat changes only the byte lanes whose `sel` bit is set, with `sel[i]` covering `dat_w[8i+7:8i]`. The change takes effect on the clock edge that ends the acknowledged cycle.
- R8: The word index is `adr[5:2]` (for 32-bit data and 16 words). The byte-offset bits `adr[1:0]` and the bits above the index are ignored, so addresses that differ only in those bits reach the same word.
- R9: An acknowledged write with `sel` all zero leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cyc | input | 1 | Bus cycle in progress |
| stb | input | 1 | Beat request strobe |
| we | input | 1 | 1 = write beat, 0 = read beat |
| adr | input | ADDR_W | Byte address |
| sel | input | DATA_W/8 | Byte-lane enables |
| dat_w | input | DATA_W | Write data |
| dat_r | output | DATA_W | Read data, valid while `ack` is high |
| ack | output | 1 | Beat acknowledge |

## Verification
In registered mode, the cycle right after an acknowledge carries two events at once: a strobe the master still holds high, which is a fresh request, and the rule that suppresses a second acknowledge. Bursts that keep `stb` high and step the address after each acknowledge create this overlap. A run passes only if N beats take exactly 2N cycles, no two acknowledges are adjacent, and every beat returns or writes its own word. In combinational mode, a write burst followed by reads over the same words checks that each acknowledged edge commits exactly the enabled lanes, while random mixed traffic is compared against a bench model of the register file.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ack_state_e;
endpackage

// File: rtl/wbs_ack_ctrl.sv
module wbs_ack_ctrl #(
    parameter bit REG_ACK = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc,
    input  logic stb,
    output logic ack,
    output logic capture
);
    import wbs_pkg::*;

    logic req;
    assign req = cyc & stb;

    generate
        if (REG_ACK) begin : g_reg
            ack_state_e state_q, state_d;

            always_ff @(posedge clk) begin
                if (rst) state_q <= ST_IDLE;
                else     state_q <= state_d;
            end

            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    ST_IDLE: state_d = req ? ST_RESP : ST_IDLE;
                    ST_RESP: state_d = ST_IDLE;
                    default: state_d = ST_IDLE;
                endcase
            end

            always_comb begin
                ack     = 1'b0;
                capture = 1'b0;
                unique case (state_q)
                    ST_IDLE: capture = req;
                    ST_RESP: ack     = req;
                    default: ;
                endcase
            end

            // R5
            no_double_ack_chk: assert property (@(posedge clk) disable iff (rst)
                ack |=> !ack);
            // R4
            one_cycle_resp_chk: assert property (@(posedge clk) disable iff (rst)
                (req && state_q == ST_IDLE) |=> (ack || !(cyc && stb)));
        end else begin : g_comb
            assign ack     = req & ~rst;
            assign capture = 1'b0;

            // R2
            same_cycle_ack_chk: assert property (@(posedge clk) disable iff (rst)
                (cyc && stb) |-> ack);
        end
    endgenerate
endmodule

// File: rtl/wbs_regmem.sv
module wbs_regmem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int SEL_W = DATA_W / 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < SEL_W; b++) begin
                if (wr_sel[b]) mem_q[wr_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            for (genvar b = 0; b < SEL_W; b++) begin : g_lane
                // R7
                lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
                    !(wr_en && wr_idx == IDX_W'(w) && wr_sel[b])
                    |=> $stable(mem_q[w][b*8 +: 8]));
            end
        end
    endgenerate
endmodule

// File: rtl/wbs_regfile_slave.sv
module wbs_regfile_slave #(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int DEPTH   = 16,
    parameter bit REG_ACK = 1'b0,
    localparam int SEL_W  = DATA_W / 8,
    localparam int OFF_W  = $clog2(SEL_W),
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc,
    input  logic              stb,
    input  logic              we,
    input  logic [ADDR_W-1:0] adr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] dat_w,
    output logic [DATA_W-1:0] dat_r,
    output logic              ack
);
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem_rd;
    logic              capture;
    logic              unused_adr;

    assign idx        = adr[OFF_W +: IDX_W];
    assign unused_adr = ^{adr[OFF_W-1:0], adr[ADDR_W-1:OFF_W+IDX_W]};

    wbs_ack_ctrl #(.REG_ACK(REG_ACK)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cyc     (cyc),
        .stb     (stb),
        .ack     (ack),
        .capture (capture)
    );

    wbs_regmem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ack & we),
        .wr_idx  (idx),
        .wr_sel  (sel),
        .wr_data (dat_w),
        .rd_idx  (idx),
        .rd_data (mem_rd)
    );

    generate
        if (REG_ACK) begin : g_rdreg
            logic [DATA_W-1:0] rdata_q;
            always_ff @(posedge clk) begin
                if (rst)          rdata_q <= '0;
                else if (capture) rdata_q <= mem_rd;
            end
            assign dat_r = rdata_q;
        end else begin : g_rdcomb
            logic unused_cap;
            assign unused_cap = capture;
            assign dat_r      = mem_rd;
        end
    endgenerate

    // R6
    idle_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
        !(cyc && stb) |-> !ack);
    // R1
    reset_ack_low_chk: assert property (@(posedge clk)
        rst |=> !ack);
endmodule

// File: tb/wbs_regfile_slave_bench.sv
module wbs_regfile_slave_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_s [2];
    logic        stb_s [2];
    logic        we_s  [2];
    logic [7:0]  adr_s [2];
    logic [3:0]  sel_s [2];
    logic [31:0] dw_s  [2];
    logic [31:0] dr_s  [2];
    logic        ack_s [2];
    logic [31:0] exp_mem [2][16];
    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    wbs_regfile_slave #(.REG_ACK(1'b0)) u_wbs_regfile_slave (
        .clk(clk), .rst(rst), .cyc(cyc_s[0]), .stb(stb_s[0]), .we(we_s[0]),
        .adr(adr_s[0]), .sel(sel_s[0]), .dat_w(dw_s[0]), .dat_r(dr_s[0]), .ack(ack_s[0]));

    wbs_regfile_slave #(.REG_ACK(1'b1)) u_wbs_regfile_slave_reg (
        .clk(clk), .rst(rst), .cyc(cyc_s[1]), .stb(stb_s[1]), .we(we_s[1]),
        .adr(adr_s[1]), .sel(sel_s[1]), .dat_w(dw_s[1]), .dat_r(dr_s[1]), .ack(ack_s[1]));

    function automatic int idx_of(input logic [7:0] a);
        return int'(a[5:2]);
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] s);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_bus(input int m);
        cyc_s[m] = 0; stb_s[m] = 0; we_s[m] = 0; adr_s[m] = 0; sel_s[m] = 0; dw_s[m] = 0;
    endtask

    // one beat; returns read data and number of wait cycles before ack
    task automatic beat(input int m, input bit w, input logic [7:0] a, input logic [3:0] s,
                        input logic [31:0] d, output logic [31:0] rd, output int lat);
        @(negedge clk);
        cyc_s[m] = 1; stb_s[m] = 1; we_s[m] = w; adr_s[m] = a; sel_s[m] = s; dw_s[m] = d;
        lat = 0;
        forever begin
            #1;
            if (ack_s[m]) break;
            lat++;
            @(negedge clk);
        end
        rd = dr_s[m];
        if (w) exp_mem[m][idx_of(a)] = merge(exp_mem[m][idx_of(a)], d, s);
        @(negedge clk);
        idle_bus(m);
    endtask

    task automatic rd_chk(input int m, input logic [7:0] a, input string req);
        logic [31:0] rd; int lat;
        logic [31:0] e;
        e = exp_mem[m][idx_of(a)];
        beat(m, 0, a, 4'h0, 32'h0, rd, lat);
        check(rd == e, req, rd, e);
        check(lat == m, m ? "R4 latency" : "R2 latency", 32'(lat), 32'(m));
    endtask

    task automatic wr(input int m, input logic [7:0] a, input logic [3:0] s,
                      input logic [31:0] d);
        logic [31:0] rd; int lat;
        beat(m, 1, a, s, d, rd, lat);
    endtask

    // held-strobe burst of n beats over consecutive words
    task automatic burst(input int m, input bit w, input int n, input int first);
        int cycles = 0, acks = 0;
        bit prev = 0, cur;
        logic [31:0] e;
        @(negedge clk);
        cyc_s[m] = 1; stb_s[m] = 1; we_s[m] = w; sel_s[m] = 4'hF;
        adr_s[m] = 8'((first % 16) * 4);
        dw_s[m] = 32'hA5000000 + 32'(first);
        while (acks < n && cycles < 4 * n) begin
            #1;
            cycles++;
            cur = ack_s[m];
            if (cur) begin
                if (w) begin
                    exp_mem[m][idx_of(adr_s[m])] = dw_s[m];
                end else begin
                    e = exp_mem[m][idx_of(adr_s[m])];
                    check(dr_s[m] == e, m ? "R4 burst data" : "R3 burst data", dr_s[m], e);
                end
                if (m == 1) check(!prev, "R5 adjacent acks", 32'(prev), 32'h0);
                acks++;
            end
            prev = cur;
            @(negedge clk);
            if (cur) begin
                adr_s[m] = 8'(((first + acks) % 16) * 4);
                dw_s[m]  = 32'hA5000000 + 32'(first + acks);
            end
        end
        idle_bus(m);
        check(cycles == n * (m + 1), m ? "R5 burst length" : "R3 burst length",
              32'(cycles), 32'(n * (m + 1)));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog (all R) actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rd, e;
        int lat;
        idle_bus(0); idle_bus(1);
        for (int m = 0; m < 2; m++) for (int i = 0; i < 16; i++) exp_mem[m][i] = '0;
        void'($urandom(32'd1234));
        // R1: ack low during reset, even with a request pending
        cyc_s[0] = 1; stb_s[0] = 1; cyc_s[1] = 1; stb_s[1] = 1;
        repeat (3) @(negedge clk);
        check(!ack_s[0] && !ack_s[1], "R1 ack in reset", {ack_s[0], ack_s[1]}, 0);
        idle_bus(0); idle_bus(1);
        @(negedge clk); rst = 0;
        @(negedge clk); #1;
        check(!ack_s[0] && !ack_s[1], "R1 ack after reset", {ack_s[0], ack_s[1]}, 0);
        for (int i = 0; i < 16; i++) rd_chk(0, 8'(i * 4), "R1 reset word");
        for (int i = 0; i < 4; i++)  rd_chk(1, 8'(i * 4), "R1 reset word");

        for (int m = 0; m < 2; m++) begin
            // R2/R4 single write + read
            wr(m, 8'h08, 4'hF, 32'hDEADBEEF);
            rd_chk(m, 8'h08, m ? "R4 read data" : "R2 read data");
            // R7 partial lanes
            wr(m, 8'h08, 4'b0101, 32'h11223344);
            rd_chk(m, 8'h08, "R7 lane select");
            check(exp_mem[m][2] == 32'hDE22BE44, "R7 lane model", exp_mem[m][2], 32'hDE22BE44);
            // R9 zero sel
            wr(m, 8'h08, 4'h0, 32'hFFFFFFFF);
            rd_chk(m, 8'h08, "R9 zero sel");
            // R8 aliasing: offset bits and upper bits ignored
            wr(m, 8'hC7, 4'hF, 32'hCAFE0001 + 32'(m));
            rd_chk(m, 8'h04, "R8 alias read");
            rd_chk(m, 8'h46, "R8 alias read");
            // R6 stb without cyc: no ack, no write
            @(negedge clk);
            cyc_s[m] = 0; stb_s[m] = 1; we_s[m] = 1; adr_s[m] = 8'h08; sel_s[m] = 4'hF;
            dw_s[m] = 32'h0BADF00D;
            for (int k = 0; k < 3; k++) begin
                #1; check(!ack_s[m], "R6 stb without cyc", 32'(ack_s[m]), 0);
                @(negedge clk);
            end
            cyc_s[m] = 1; stb_s[m] = 0;
            for (int k = 0; k < 3; k++) begin
                #1; check(!ack_s[m], "R6 cyc without stb", 32'(ack_s[m]), 0);
                @(negedge clk);
            end
            idle_bus(m);
            rd_chk(m, 8'h08, "R6 no write");
            // R3/R5 bursts: write then read back
            burst(m, 1, 6, 5);
            burst(m, 0, 6, 5);
            burst(m, 0, 16, 0);
        end

        // random mixed traffic against the model (R7 R2 R4)
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 150; k++) begin
                logic [7:0]  a = 8'($urandom);
                logic [3:0]  s = 4'($urandom);
                logic [31:0] d = $urandom;
                if ($urandom % 2) begin
                    wr(m, a, s, d);
                end else begin
                    e = exp_mem[m][idx_of(a)];
                    beat(m, 0, a, 4'h0, 32'h0, rd, lat);
                    check(rd == e, "R7 random read", rd, e);
                    check(lat == m, m ? "R4 random latency" : "R2 random latency",
                          32'(lat), 32'(m));
                end
            end
        end

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule